// File: doc/BRIEF.md
# Vector Mask Unary Unit

This block performs the element-serial mask-unary operations of a vector ALU. The five operations are set-before-first, set-including-first, set-only-first, prefix count (iota) and element index. Each cycle the caller presents one source mask bit together with its element index, a valid strobe, an active flag, a 5-bit operation code and the element width of the destination. The block returns one destination element per cycle, one clock later.

The block keeps two pieces of state between elements: a flag that records whether a set source bit has already been seen, and a running count of set source bits. Element index 0 starts a new vector and clears both. The three set-first operations yield a single mask bit, zero-extended on the 32-bit result bus. Iota and element index yield a value cut to 8, 16 or 32 bits.

An inactive element, or an element with an unknown code, is not written. In both cases the caller's previous destination value is passed straight through.

Top module: `mask_unary_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_valid, out_write, out_illegal and out_data are all 0.
- R2: out_valid is high in the cycle after in_valid was high, and low in the cycle after in_valid was low.
- R3: Code 5'b00001 (set-before-first) writes 1 when no active set source bit has been seen at a lower index and the current bit is 0. It writes 0 otherwise. The result sits in bit 0, and bits 31:1 are 0.
- R4: Code 5'b00011 (set-including-first) writes 1 when no active set source bit has been seen at a lower index, whatever the current bit is. It writes 0 otherwise.
- R5: Code 5'b00010 (set-only-first) writes 1 only at the first active set source bit, and 0 at every other element.
- R6: Code 5'b10000 (iota) writes the number of active set source bits at lower indices. The value is cut to the element width: in_sew 00 gives 8 bits, 01 gives 16 bits, and 10 or 11 give 32 bits. The upper bits are 0.
- R7: Code 5'b10001 (element index) writes in_index, cut to the element width in the same way as R6. The source bit has no effect.
- R8: An element with index 0 clears the seen flag and the count before it is processed, so that element sees a fresh vector.
- R9: An inactive element gives out_write=0 and out_data=in_keep. It does not change the seen flag or the count.
- R10: Any other code gives out_illegal=1, out_write=0 and out_data=in_keep. It leaves the seen flag and the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An element is presented this cycle |
| in_active | input | 1 | The element is active (not masked off) |
| in_code | input | 5 | Operation code |
| in_index | input | IDX_W | Element index |
| in_src | input | 1 | Source mask bit |
| in_sew | input | 2 | Destination element width: 00 = 8, 01 = 16, 1x = 32 |
| in_keep | input | 32 | Previous destination value, passed through when the element is not written |
| out_valid | output | 1 | Result element present |
| out_write | output | 1 | The result element is to be written |
| out_illegal | output | 1 | The code was not recognised |
| out_data | output | 32 | Result element |

## Verification
Every result is registered once, so the outputs for an element are due on the first rising edge after that element is presented. The bench drives each element on a falling edge, waits for the next rising edge, and samples 1 ns later, before any new element is applied. The seen flag and the count carry over from one element to the next. The bench therefore works out each expected value from the whole prefix of the stream it has sent, never from the previous output. The state that an inactive or illegal element must leave untouched is then observed in later results of the same vector.

// File: rtl/mu_pkg.sv
package mu_pkg;

  localparam int DATA_W = 32;

  localparam logic [4:0] CODE_BEFORE  = 5'b00001;
  localparam logic [4:0] CODE_ONLY    = 5'b00010;
  localparam logic [4:0] CODE_INCL    = 5'b00011;
  localparam logic [4:0] CODE_PREFIX  = 5'b10000;
  localparam logic [4:0] CODE_ELEMIDX = 5'b10001;

  typedef enum logic [2:0] {
    OP_BEFORE,
    OP_ONLY,
    OP_INCL,
    OP_PREFIX,
    OP_ELEMIDX,
    OP_NONE
  } mu_op_e;

  // Cut a value to the destination element width, clearing the upper bits.
  function automatic logic [DATA_W-1:0] fit_width(logic [DATA_W-1:0] v, logic [1:0] sew);
    logic [DATA_W-1:0] r;
    case (sew)
      2'b00:   r = {24'd0, v[7:0]};
      2'b01:   r = {16'd0, v[15:0]};
      default: r = v;
    endcase
    return r;
  endfunction

  // Bit result of the set-first family, given the prior seen flag and the current bit.
  function automatic logic first_bit(mu_op_e op, logic seen, logic src);
    logic r;
    case (op)
      OP_BEFORE: r = !seen && !src;
      OP_INCL:   r = !seen;
      OP_ONLY:   r = !seen && src;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mu_decode.sv
module mu_decode
  import mu_pkg::*;
(
  input  logic [4:0] code,
  output mu_op_e     op,
  output logic       legal
);
  always_comb begin
    case (code)
      CODE_BEFORE:  op = OP_BEFORE;
      CODE_ONLY:    op = OP_ONLY;
      CODE_INCL:    op = OP_INCL;
      CODE_PREFIX:  op = OP_PREFIX;
      CODE_ELEMIDX: op = OP_ELEMIDX;
      default:      op = OP_NONE;
    endcase
    legal = (op != OP_NONE);
  end
endmodule

// File: rtl/mu_track.sv
module mu_track #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             restart,
  input  logic             advance,
  input  logic             src,
  output logic             seen_eff,
  output logic [CNT_W-1:0] count_eff,
  output logic             found_q,
  output logic [CNT_W-1:0] count_q
);
  // Element zero sees a cleared state whatever the stored values are.
  assign seen_eff  = restart ? 1'b0 : found_q;
  assign count_eff = restart ? '0 : count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found_q <= 1'b0;
      count_q <= '0;
    end else if (step) begin
      if (advance) begin
        found_q <= seen_eff | src;
        count_q <= count_eff + CNT_W'(src);
      end else if (restart) begin
        found_q <= 1'b0;
        count_q <= '0;
      end
    end
  end
endmodule

// File: rtl/mu_result.sv
module mu_result
  import mu_pkg::*;
#(
  parameter int IDX_W = 12,
  parameter int CNT_W = 12
) (
  input  mu_op_e            op,
  input  logic              seen,
  input  logic [CNT_W-1:0]  count,
  input  logic [IDX_W-1:0]  index,
  input  logic              src,
  input  logic [1:0]        sew,
  output logic [DATA_W-1:0] value
);
  always_comb begin
    case (op)
      OP_PREFIX:  value = fit_width(DATA_W'(count), sew);
      OP_ELEMIDX: value = fit_width(DATA_W'(index), sew);
      default:    value = {{(DATA_W-1){1'b0}}, first_bit(op, seen, src)};
    endcase
  end
endmodule

// File: rtl/mask_unary_unit.sv
module mask_unary_unit
  import mu_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_active,
  input  logic [4:0]       in_code,
  input  logic [IDX_W-1:0] in_index,
  input  logic             in_src,
  input  logic [1:0]       in_sew,
  input  logic [31:0]      in_keep,
  output logic             out_valid,
  output logic             out_write,
  output logic             out_illegal,
  output logic [31:0]      out_data
);
  localparam int CNT_W = IDX_W;

  mu_op_e           op;
  logic             legal;
  logic             restart;
  logic             advance;
  logic             seen_eff;
  logic [CNT_W-1:0] count_eff;
  logic             found_q;
  logic [CNT_W-1:0] count_q;
  logic [31:0]      value;

  assign restart = (in_index == '0);
  assign advance = in_active && legal;

  mu_decode u_dec (
    .code  (in_code),
    .op    (op),
    .legal (legal)
  );

  mu_track #(.CNT_W(CNT_W)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (in_valid),
    .restart   (restart),
    .advance   (advance),
    .src       (in_src),
    .seen_eff  (seen_eff),
    .count_eff (count_eff),
    .found_q   (found_q),
    .count_q   (count_q)
  );

  mu_result #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_res (
    .op    (op),
    .seen  (seen_eff),
    .count (count_eff),
    .index (in_index),
    .src   (in_src),
    .sew   (in_sew),
    .value (value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_write   <= 1'b0;
      out_illegal <= 1'b0;
      out_data    <= '0;
    end else begin
      out_valid   <= in_valid;
      out_write   <= in_valid && advance;
      out_illegal <= in_valid && !legal;
      if (in_valid) begin
        out_data <= advance ? value : in_keep;
      end
    end
  end
endmodule

// File: rtl/mu_checker.sv
module mu_checker #(
  parameter int IDX_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_active,
  input logic [4:0]       in_code,
  input logic [IDX_W-1:0] in_index,
  input logic [1:0]       in_sew,
  input logic [31:0]      in_keep,
  input logic             out_valid,
  input logic             out_write,
  input logic             out_illegal,
  input logic [31:0]      out_data,
  input logic             found_q,
  input logic [IDX_W-1:0] count_q
);
  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  idle_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R10
  illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> !out_write);
  // R9
  inactive_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_active) |=> (!out_write && out_data == $past(in_keep)));
  // R9
  inactive_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_active && in_index != '0) |=> ($stable(found_q) && $stable(count_q)));
  // R8
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_active && in_index == '0) |=> (!found_q && count_q == '0));
  // R5
  only_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_active && in_code == 5'b00010 && in_index != '0 && found_q)
      |=> (out_write && out_data == 32'd0));
  // R4
  incl_before_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_active && in_code == 5'b00011 && in_index != '0 && !found_q)
      |=> (out_write && out_data == 32'd1));
  // R7
  index_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_active && in_code == 5'b10001 && in_sew == 2'b10)
      |=> (out_data == 32'($past(in_index))));
endmodule

bind mask_unary_unit mu_checker #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/mask_unary_unit_test.sv
module mask_unary_unit_test;
  localparam int IDX_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_active = 1'b0;
  logic [4:0]       in_code = 5'd0;
  logic [IDX_W-1:0] in_index = '0;
  logic             in_src = 1'b0;
  logic [1:0]       in_sew = 2'b10;
  logic [31:0]      in_keep = 32'd0;
  logic             out_valid, out_write, out_illegal;
  logic [31:0]      out_data;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mask_unary_unit #(.IDX_W(IDX_W)) uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Present one element; outputs are sampled 1 ns after the capturing edge.
  task automatic send(logic [4:0] code, int idx, logic src, logic act,
                      logic [1:0] sew, logic [31:0] keep);
    @(negedge clk);
    in_valid = 1'b1; in_code = code; in_index = IDX_W'(idx);
    in_src = src; in_active = act; in_sew = sew; in_keep = keep;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // Reference for the set-first family: prior active set bits decide.
  function automatic logic ref_bit(logic [4:0] code, logic [63:0] bits,
                                   logic [63:0] act, int i);
    logic seen = 1'b0;
    for (int j = 0; j < i; j++) if (bits[j] && act[j]) seen = 1'b1;
    case (code)
      5'b00001: return !seen && !bits[i];
      5'b00011: return !seen;
      default:  return !seen && bits[i];
    endcase
  endfunction

  task automatic run_first(string req, logic [4:0] code, logic [63:0] bits,
                           logic [63:0] act, int n);
    for (int i = 0; i < n; i++) begin
      send(code, i, bits[i], act[i], 2'b10, 32'hCAFE_0000 + i);
      if (act[i]) begin
        check(req, {31'd0, out_write}, 32'd1);
        check(req, out_data, {31'd0, ref_bit(code, bits, act, i)});
      end else begin
        check({req, "/R9"}, {31'd0, out_write}, 32'd0);
        check({req, "/R9"}, out_data, 32'hCAFE_0000 + i);
      end
    end
  endtask

  task automatic t_reset;
    check("R1 valid", {31'd0, out_valid}, 32'd0);
    check("R1 write", {31'd0, out_write}, 32'd0);
    check("R1 illegal", {31'd0, out_illegal}, 32'd0);
    check("R1 data", out_data, 32'd0);
  endtask

  task automatic t_latency;
    send(5'b10001, 5, 1'b0, 1'b1, 2'b10, 32'd0);
    check("R2 valid high", {31'd0, out_valid}, 32'd1);
    @(posedge clk); #1;
    check("R2 valid low", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_before;
    run_first("R3 a", 5'b00001, 64'b0010_1000, 64'hFF, 8);
    run_first("R3 none", 5'b00001, 64'b0, 64'hFF, 6);
    run_first("R3 at0", 5'b00001, 64'b1, 64'hFF, 4);
  endtask

  task automatic t_incl;
    run_first("R4 a", 5'b00011, 64'b0100_1000, 64'hFF, 8);
    run_first("R4 at0", 5'b00011, 64'b0101, 64'hF, 4);
  endtask

  task automatic t_only;
    run_first("R5 a", 5'b00010, 64'b1011_0100, 64'hFF, 8);
    run_first("R5 at0", 5'b00010, 64'b1001, 64'hF, 4);
  endtask

  task automatic t_prefix;
    logic [63:0] bits = 64'b1101_0110_1011;
    int cnt = 0;
    for (int i = 0; i < 12; i++) begin
      send(5'b10000, i, bits[i], 1'b1, 2'b01, 32'hFFFF_FFFF);
      check("R6 iota", out_data, 32'(cnt));
      cnt += int'(bits[i]);
    end
    // Count wraps at 8 bits: 259 set bits before element 259 reads as 3.
    for (int i = 0; i < 260; i++) begin
      send(5'b10000, i, 1'b1, 1'b1, 2'b00, 32'd0);
      if (i == 255) check("R6 iota sew8", out_data, 32'd255);
      if (i == 259) check("R6 iota wrap", out_data, 32'd3);
    end
  endtask

  task automatic t_index;
    send(5'b10001, 300, 1'b1, 1'b1, 2'b00, 32'd0);
    check("R7 sew8", out_data, 32'd44);
    send(5'b10001, 300, 1'b0, 1'b1, 2'b01, 32'd0);
    check("R7 sew16", out_data, 32'd300);
    send(5'b10001, 4095, 1'b1, 1'b1, 2'b10, 32'd0);
    check("R7 sew32 src1", out_data, 32'd4095);
    send(5'b10001, 4095, 1'b0, 1'b1, 2'b11, 32'd0);
    check("R7 sew32 src0", out_data, 32'd4095);
  endtask

  task automatic t_restart;
    send(5'b00010, 0, 1'b0, 1'b1, 2'b10, 32'd0);
    send(5'b00010, 1, 1'b1, 1'b1, 2'b10, 32'd0);
    check("R8 first", out_data, 32'd1);
    send(5'b00010, 0, 1'b1, 1'b1, 2'b10, 32'd0);
    check("R8 restart", out_data, 32'd1);
    send(5'b10000, 0, 1'b1, 1'b1, 2'b10, 32'd0);
    check("R8 count0", out_data, 32'd0);
  endtask

  task automatic t_inactive;
    // Element 2 is inactive with a set bit; first active set bit is element 4.
    run_first("R9 only", 5'b00010, 64'b0001_0100, 64'b1111_1011, 8);
    run_first("R9 before", 5'b00001, 64'b0000_0110, 64'b1111_1101, 8);
  endtask

  task automatic t_illegal;
    send(5'b10000, 0, 1'b1, 1'b1, 2'b10, 32'd0);
    send(5'b00111, 1, 1'b1, 1'b1, 2'b10, 32'h1234_5678);
    check("R10 flag", {31'd0, out_illegal}, 32'd1);
    check("R10 write", {31'd0, out_write}, 32'd0);
    check("R10 data", out_data, 32'h1234_5678);
    send(5'b10000, 2, 1'b0, 1'b1, 2'b10, 32'd0);
    check("R10 count kept", out_data, 32'd1);
    check("R10 flag clear", {31'd0, out_illegal}, 32'd0);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_latency();
    t_before();
    t_incl();
    t_only();
    t_prefix();
    t_index();
    t_restart();
    t_inactive();
    t_illegal();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule